// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Block

This block gathers the event flags of an SD host controller into one interrupt request line. The command engine, the data engine and the card-detect logic each raise single-cycle pulses. The block latches each pulse into a 32-bit status register. A 32-bit mask register gates the status register, and any unmasked pending bit drives the active-low interrupt output. A second, 16-bit status and mask pair holds interrupts from SDIO cards and feeds the same output.

Software reaches the block over a 16-bit register bus. Each 32-bit register is split across two consecutive 16-bit slots: the low half sits at byte offset a and the high half at a+2. Every offset is shifted left by a build-time bus shift of 0 or 1 before it is decoded. Software acknowledges events by writing zeros: a zero clears the matching status bit and a one leaves it as it is, so writing the complement of a set of bits acknowledges exactly that set. The write-protect flag is not latched. It follows its input pin at all times.

Top module: `sdh_irq_regs`

## Requirements
- R1: After a synchronous reset, every status bit reads 0, both halves of the mask and the SDIO mask read 0xFFFF, and irq_n is 1.
- R2: A one-cycle pulse on evt_set sets its status bit, and the bit stays set until it is cleared. The latched bits are: 0 command response end, 2 data end, 3 card removed, 4 card inserted, 8 command timeout, 9 CRC failure, 10 receive overflow, 11 transmit underrun, 16 receive ready, 17 transmit request.
- R3: A bus write to a status half clears each bit where the data is 0 and leaves each bit where the data is 1. The other half is not changed.
- R4: An event pulse in the same cycle as a write that clears its bit leaves that bit set.
- R5: Status low/high sit at byte offsets 0x1C/0x1E, mask low/high at 0x20/0x22, SDIO status at 0x36 and SDIO mask at 0x38, each shifted left by BUS_SHIFT. A write to any other address changes no state, and a read of any other address returns 0.
- R6: Mask registers read back what was written. Setting a mask bit to 1 blocks its source, and clearing it to 0 enables the source.
- R7: irq_n is 0 exactly when some status or SDIO status bit is set and its mask bit is 0.
- R8: Status bit 7 reads the current level of wp_level. Writes do not affect it, and while it is 1 it raises an interrupt if mask bit 7 is 0.
- R9: Status bits that are not listed in R2 or R8 always read 0, even when they receive an event pulse.
- R10: SDIO status bit 0 latches io_card_irq. It is cleared by writing 0 to it and is gated by SDIO mask bit 0. The other SDIO status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 1 | Bus access strobe |
| reg_we | input | 1 | Write when 1, read when 0 |
| reg_addr | input | ADDR_W | Byte address of the 16-bit slot |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| evt_set | input | 32 | Event pulses, one per status bit |
| wp_level | input | 1 | Write-protect level |
| io_card_irq | input | 1 | SDIO card interrupt pulse |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with BUS_SHIFT set to 1, so every slot address is doubled. It also writes to the unshifted offset of a status register, which checks that scaled and unscaled decoding are told apart. Simultaneous clear-and-set cycles, writes to the odd slot between the two halves, and an all-ones event pulse cover priority, decode holes and the undefined bits. The default shift of 0 is covered by elaboration only.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

    localparam int STAT_W = 32;
    localparam int HALF_W = 16;

    localparam int EV_CMD_DONE = 0;
    localparam int EV_DATA_END = 2;
    localparam int EV_CARD_OUT = 3;
    localparam int EV_CARD_IN  = 4;
    localparam int EV_WPROT    = 7;
    localparam int EV_CMD_TMO  = 8;
    localparam int EV_CRC_ERR  = 9;
    localparam int EV_RX_OVF   = 10;
    localparam int EV_TX_UND   = 11;
    localparam int EV_RX_RDY   = 16;
    localparam int EV_TX_REQ   = 17;
    localparam int IO_CARD_INT = 0;

    function automatic logic [STAT_W-1:0] bitv(input int pos);
        return STAT_W'(1) << pos;
    endfunction

    localparam logic [STAT_W-1:0] EVT_LATCH =
        bitv(EV_CMD_DONE) | bitv(EV_DATA_END) | bitv(EV_CARD_OUT) |
        bitv(EV_CARD_IN)  | bitv(EV_CMD_TMO)  | bitv(EV_CRC_ERR)  |
        bitv(EV_RX_OVF)   | bitv(EV_TX_UND)   | bitv(EV_RX_RDY)   |
        bitv(EV_TX_REQ);

    localparam logic [HALF_W-1:0] IO_LATCH = HALF_W'(1) << IO_CARD_INT;

    localparam int OFS_STAT    = 'h1C;
    localparam int OFS_MASK    = 'h20;
    localparam int OFS_IO_STAT = 'h36;
    localparam int OFS_IO_MASK = 'h38;

    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_STAT_LO,
        SLOT_STAT_HI,
        SLOT_MASK_LO,
        SLOT_MASK_HI,
        SLOT_IO_STAT,
        SLOT_IO_MASK
    } slot_e;

    typedef struct packed {
        logic stat_lo;
        logic stat_hi;
        logic mask_lo;
        logic mask_hi;
        logic io_stat;
        logic io_mask;
    } slot_hit_t;

    function automatic logic [STAT_W-1:0] spread(input logic lo, input logic hi,
                                                 input logic [HALF_W-1:0] d);
        return {(hi ? d : '0), (lo ? d : '0)};
    endfunction

endpackage

// File: rtl/sdh_irq_decode.sv
module sdh_irq_decode
    import sdh_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUS_SHIFT = 0
) (
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    output slot_e             rd_slot,
    output slot_hit_t         wr_hit
);
    localparam logic [ADDR_W-1:0] A_STAT_LO = ADDR_W'(OFS_STAT << BUS_SHIFT);
    localparam logic [ADDR_W-1:0] A_STAT_HI = ADDR_W'((OFS_STAT + 2) << BUS_SHIFT);
    localparam logic [ADDR_W-1:0] A_MASK_LO = ADDR_W'(OFS_MASK << BUS_SHIFT);
    localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'((OFS_MASK + 2) << BUS_SHIFT);
    localparam logic [ADDR_W-1:0] A_IO_STAT = ADDR_W'(OFS_IO_STAT << BUS_SHIFT);
    localparam logic [ADDR_W-1:0] A_IO_MASK = ADDR_W'(OFS_IO_MASK << BUS_SHIFT);

    logic wr_go;

    always_comb begin
        case (reg_addr)
            A_STAT_LO: rd_slot = SLOT_STAT_LO;
            A_STAT_HI: rd_slot = SLOT_STAT_HI;
            A_MASK_LO: rd_slot = SLOT_MASK_LO;
            A_MASK_HI: rd_slot = SLOT_MASK_HI;
            A_IO_STAT: rd_slot = SLOT_IO_STAT;
            A_IO_MASK: rd_slot = SLOT_IO_MASK;
            default:   rd_slot = SLOT_NONE;
        endcase
    end

    assign wr_go = reg_sel && reg_we;

    always_comb begin
        wr_hit.stat_lo = wr_go && (rd_slot == SLOT_STAT_LO);
        wr_hit.stat_hi = wr_go && (rd_slot == SLOT_STAT_HI);
        wr_hit.mask_lo = wr_go && (rd_slot == SLOT_MASK_LO);
        wr_hit.mask_hi = wr_go && (rd_slot == SLOT_MASK_HI);
        wr_hit.io_stat = wr_go && (rd_slot == SLOT_IO_STAT);
        wr_hit.io_mask = wr_go && (rd_slot == SLOT_IO_MASK);
    end
endmodule

// File: rtl/sdh_irq_latch.sv
module sdh_irq_latch #(
    parameter int              WIDTH = 32,
    parameter logic [WIDTH-1:0] LATCH = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (LATCH[i]) begin : g_ff
            always_ff @(posedge clk) begin
                if (rst)         q[i] <= 1'b0;
                else if (set[i]) q[i] <= 1'b1;
                else if (clr[i]) q[i] <= 1'b0;
            end
        end else begin : g_zero
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sdh_irq_bitreg.sv
module sdh_irq_bitreg #(
    parameter int               WIDTH   = 32,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] wr_en,
    input  logic [WIDTH-1:0] wr_val,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= (q & ~wr_en) | (wr_val & wr_en);
    end
endmodule

// File: rtl/sdh_irq_regs.sv
module sdh_irq_regs
    import sdh_irq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUS_SHIFT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [31:0]       evt_set,
    input  logic              wp_level,
    input  logic              io_card_irq,
    output logic              irq_n
);
    localparam logic [ADDR_W-1:0] STAT_LO_A = ADDR_W'(OFS_STAT << BUS_SHIFT);

    slot_e              rd_slot;
    slot_hit_t          wr_hit;
    logic [STAT_W-1:0]  clr_stat;
    logic [STAT_W-1:0]  stat_lat;
    logic [STAT_W-1:0]  stat_view;
    logic [STAT_W-1:0]  mask_q;
    logic [STAT_W-1:0]  mask_wen;
    logic [HALF_W-1:0]  io_clr;
    logic [HALF_W-1:0]  io_stat;
    logic [HALF_W-1:0]  io_mask;
    logic               pend_main;
    logic               pend_io;

    sdh_irq_decode #(.ADDR_W(ADDR_W), .BUS_SHIFT(BUS_SHIFT)) u_dec (
        .reg_sel (reg_sel),
        .reg_we  (reg_we),
        .reg_addr(reg_addr),
        .rd_slot (rd_slot),
        .wr_hit  (wr_hit)
    );

    assign clr_stat = spread(wr_hit.stat_lo, wr_hit.stat_hi, ~reg_wdata);

    sdh_irq_latch #(.WIDTH(STAT_W), .LATCH(EVT_LATCH)) u_stat (
        .clk(clk), .rst(rst), .set(evt_set), .clr(clr_stat), .q(stat_lat)
    );

    assign mask_wen = spread(wr_hit.mask_lo, wr_hit.mask_hi, '1);

    sdh_irq_bitreg #(.WIDTH(STAT_W), .RST_VAL('1)) u_mask (
        .clk(clk), .rst(rst), .wr_en(mask_wen), .wr_val({reg_wdata, reg_wdata}),
        .q(mask_q)
    );

    assign io_clr = wr_hit.io_stat ? ~reg_wdata : '0;

    sdh_irq_latch #(.WIDTH(HALF_W), .LATCH(IO_LATCH)) u_io_stat (
        .clk(clk), .rst(rst), .set(HALF_W'(io_card_irq) << IO_CARD_INT),
        .clr(io_clr), .q(io_stat)
    );

    sdh_irq_bitreg #(.WIDTH(HALF_W), .RST_VAL('1)) u_io_mask (
        .clk(clk), .rst(rst), .wr_en({HALF_W{wr_hit.io_mask}}), .wr_val(reg_wdata),
        .q(io_mask)
    );

    assign stat_view = stat_lat | (STAT_W'(wp_level) << EV_WPROT);

    always_comb begin
        case (rd_slot)
            SLOT_STAT_LO: reg_rdata = stat_view[15:0];
            SLOT_STAT_HI: reg_rdata = stat_view[31:16];
            SLOT_MASK_LO: reg_rdata = mask_q[15:0];
            SLOT_MASK_HI: reg_rdata = mask_q[31:16];
            SLOT_IO_STAT: reg_rdata = io_stat;
            SLOT_IO_MASK: reg_rdata = io_mask;
            default:      reg_rdata = '0;
        endcase
    end

    assign pend_main = |(stat_view & ~mask_q);
    assign pend_io   = |(io_stat & ~io_mask);
    assign irq_n     = ~(pend_main | pend_io);
endmodule

// File: rtl/sdh_irq_chk.sv
module sdh_irq_chk
    import sdh_irq_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_LO_A = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [15:0]       reg_rdata,
    input logic [31:0]       evt_set,
    input logic              wp_level,
    input logic              irq_n,
    input logic [31:0]       stat_lat,
    input logic [31:0]       clr_stat,
    input logic [31:0]       mask_q,
    input logic [15:0]       io_mask
);
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|(evt_set & EVT_LATCH)) |=>
        ((stat_lat & $past(evt_set & EVT_LATCH)) == $past(evt_set & EVT_LATCH))); // R4

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (evt_set == '0 && clr_stat == '0) |=> $stable(stat_lat)); // R3

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (stat_lat & ~EVT_LATCH) == '0); // R9

    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (&mask_q && &io_mask) |-> irq_n); // R6

    AST_WP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == STAT_LO_A) |-> (reg_rdata[EV_WPROT] == wp_level)); // R8
endmodule

bind sdh_irq_regs sdh_irq_chk #(.ADDR_W(ADDR_W), .STAT_LO_A(STAT_LO_A)) u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .evt_set(evt_set), .wp_level(wp_level), .irq_n(irq_n),
    .stat_lat(stat_lat), .clr_stat(clr_stat), .mask_q(mask_q), .io_mask(io_mask)
);

// File: tb/test_sdh_irq_regs.sv
module test_sdh_irq_regs;
    localparam int AW = 8;
    localparam logic [AW-1:0] SL = 8'h38, SH = 8'h3C, ML = 8'h40, MH = 8'h44;
    localparam logic [AW-1:0] IS = 8'h6C, IM = 8'h70;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_sel = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [31:0]   evt_set = '0;
    logic          wp_level = 1'b0;
    logic          io_card_irq = 1'b0;
    logic          irq_n;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sdh_irq_regs #(.ADDR_W(AW), .BUS_SHIFT(1)) i_sdh_irq_regs (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_set(evt_set), .wp_level(wp_level), .io_card_irq(io_card_irq),
        .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                      input logic [31:0] ev = '0);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; evt_set = ev;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; evt_set = '0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
        reg_addr = a;
        #1;
        check(req, {16'h0, reg_rdata}, {16'h0, exp});
    endtask

    task automatic pulse(input logic [31:0] ev, input logic io);
        @(negedge clk);
        evt_set = ev; io_card_irq = io;
        @(negedge clk);
        evt_set = '0; io_card_irq = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk(SL, 16'h0000, "R1 stat lo");
        rd_chk(SH, 16'h0000, "R1 stat hi");
        rd_chk(ML, 16'hFFFF, "R1 mask lo");
        rd_chk(MH, 16'hFFFF, "R1 mask hi");
        rd_chk(IM, 16'hFFFF, "R1 io mask");
        check("R1 irq_n", irq_n, 1);
    endtask

    task automatic t_latch_and_mask;
        pulse(32'h0001_0001, 1'b0);
        repeat (2) @(negedge clk);
        rd_chk(SL, 16'h0001, "R2 cmd done held");
        rd_chk(SH, 16'h0001, "R2 rx ready held");
        check("R6 masked no irq", irq_n, 1);
        wr(ML, 16'hFFFE);
        rd_chk(ML, 16'hFFFE, "R6 mask readback");
        check("R7 unmasked irq", irq_n, 0);
        wr(ML, 16'hFFFF);
        check("R7 remasked", irq_n, 1);
        wr(MH, 16'hFFFE);
        check("R7 high half irq", irq_n, 0);
        wr(MH, 16'hFFFF);
    endtask

    task automatic t_ack;
        wr(SL, 16'hFFFE);
        rd_chk(SL, 16'h0000, "R3 ack low");
        rd_chk(SH, 16'h0001, "R3 high untouched");
        wr(SH, 16'hFFFF);
        rd_chk(SH, 16'h0001, "R3 ones keep");
        wr(SH, 16'hFFFE);
        rd_chk(SH, 16'h0000, "R3 ack high");
    endtask

    task automatic t_race;
        pulse(32'h0000_0008, 1'b0);
        rd_chk(SL, 16'h0008, "R2 card out");
        wr(SL, 16'h0000, 32'h0000_0004);
        rd_chk(SL, 16'h0004, "R4 set beats clear");
        wr(SL, 16'h0000);
        rd_chk(SL, 16'h0000, "R3 clear all");
    endtask

    task automatic t_undef;
        pulse(32'hFFFF_FFFF, 1'b0);
        rd_chk(SL, 16'h0F1D, "R9 low valid only");
        rd_chk(SH, 16'h0003, "R9 high valid only");
        wr(SL, 16'h0000);
        wr(SH, 16'h0000);
        rd_chk(SL, 16'h0000, "R3 cleared lo");
        rd_chk(SH, 16'h0000, "R3 cleared hi");
    endtask

    task automatic t_wp;
        @(negedge clk); wp_level = 1'b1;
        rd_chk(SL, 16'h0080, "R8 wp follows");
        wr(SL, 16'h0000);
        rd_chk(SL, 16'h0080, "R8 write ignored");
        check("R8 masked wp", irq_n, 1);
        wr(ML, 16'hFF7F);
        check("R8 wp irq", irq_n, 0);
        @(negedge clk); wp_level = 1'b0;
        #1;
        check("R8 wp drop irq", irq_n, 1);
        rd_chk(SL, 16'h0000, "R8 wp low");
        wr(ML, 16'hFFFF);
    endtask

    task automatic t_decode;
        pulse(32'h0000_0001, 1'b0);
        wr(8'h3A, 16'h0000);
        rd_chk(SL, 16'h0001, "R5 hole write ignored");
        rd_chk(8'h3A, 16'h0000, "R5 hole reads zero");
        wr(8'h1C, 16'h0000);
        rd_chk(SL, 16'h0001, "R5 unshifted ignored");
        wr(8'h20, 16'h0000);
        rd_chk(ML, 16'hFFFF, "R5 unshifted mask ignored");
        wr(SL, 16'hFFFE);
        rd_chk(SL, 16'h0000, "R5 shifted hit");
    endtask

    task automatic t_io;
        pulse(32'h0, 1'b1);
        rd_chk(IS, 16'h0001, "R10 io latch");
        check("R10 io masked", irq_n, 1);
        wr(IM, 16'hFFFE);
        rd_chk(IM, 16'hFFFE, "R10 io mask readback");
        check("R10 io irq", irq_n, 0);
        wr(IS, 16'hFFFE);
        rd_chk(IS, 16'h0000, "R10 io ack");
        check("R10 io irq drop", irq_n, 1);
        wr(IM, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latch_and_mask();
        t_ack();
        t_race();
        t_undef();
        t_wp();
        t_decode();
        t_io();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule